// File: doc/BRIEF.md
# Dime and Quarter Vending Controller

This block is the money-counting core of a small vending machine. On every clock edge it samples a two-bit coin code that marks a dime, a quarter, no coin, or an illegal code. Its four-state register records how much credit has built up. When a coin brings the credit to the sale threshold, the block fires a single-cycle dispense pulse and returns to idle.

The state register is visible at the ports as two bits named X and Y. X sits in bit 1 and Y in bit 0. The states are encoded as follows:

| State | X | Y | `acc_state` |
|-------|---|---|-------------|
| idle | 0 | 0 | `00` |
| one dime | 1 | 0 | `10` |
| two dimes | 0 | 1 | `01` |
| one quarter | 1 | 1 | `11` |

The coin code is `coin_code[1]` = quarter flag and `coin_code[0]` = dime flag. The code `10` is a quarter and `01` is a dime. The codes `00` and `11` carry no coin. Change return, coin validation and display logic lie outside this block.

Top module: `coin_vend_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the next state is `acc_state` = `00` and `vend` = 0, whatever `coin_code` carries.
- R2: Code `00` (no coin) leaves `acc_state` unchanged and `vend` low after that edge.
- R3: Code `11` is illegal and acts like no coin: `acc_state` holds and `vend` stays low.
- R4: From idle (`00`), a dime (code `01`) moves to `10` and a quarter (code `10`) moves to `11`. Neither raises `vend`.
- R5: From `10`, a dime moves to `01` with no dispense, and a quarter returns to `00` with `vend` high.
- R6: From `01`, either a dime or a quarter returns to `00` with `vend` high.
- R7: From `11`, either a dime or a quarter returns to `00` with `vend` high.
- R8: `vend` is a registered output. It goes high in the cycle after the edge that sampled the qualifying coin, lasts exactly one cycle, and is only ever high while `acc_state` is `00`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| coin_code | input | 2 | Coin code: bit 1 = quarter, bit 0 = dime |
| acc_state | output | 2 | Credit state register: bit 1 = X, bit 0 = Y |
| vend | output | 1 | One-cycle registered dispense pulse |

## Verification
The state register is a port, so a wrong transition shows at `acc_state` in the cycle right after the coin edge. A wrong state that happens to look correct in its encoding shows up as a missing, extra or misplaced `vend` pulse when the next coin arrives, at most one coin later. The bench walks every state through every coin code, including runs of coins held for back-to-back cycles. This exposes a pulse that lasts too long or a credit that is lost across a dispense.

// File: rtl/vend_pkg.sv
package vend_pkg;

  localparam int unsigned CODE_W    = 2;
  localparam int unsigned STATE_W   = 2;
  localparam int unsigned QTR_BIT   = 1;
  localparam int unsigned DIME_BIT  = 0;

  // bit 1 = X, bit 0 = Y
  typedef enum logic [STATE_W-1:0] {
    ST_IDLE  = 2'b00,
    ST_TEN   = 2'b10,
    ST_TWENTY= 2'b01,
    ST_QTR   = 2'b11
  } vstate_t;

  typedef enum logic [1:0] {
    COIN_NONE    = 2'd0,
    COIN_DIME    = 2'd1,
    COIN_QUARTER = 2'd2,
    COIN_BAD     = 2'd3
  } coin_kind_t;

endpackage

// File: rtl/vend_coin_decode.sv
module vend_coin_decode
  import vend_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output coin_kind_t        kind
);

  logic has_dime;
  logic has_qtr;

  assign has_dime = code[DIME_BIT];
  assign has_qtr  = code[QTR_BIT];

  always_comb begin
    unique case ({has_qtr, has_dime})
      2'b01:   kind = COIN_DIME;
      2'b10:   kind = COIN_QUARTER;
      2'b11:   kind = COIN_BAD;
      default: kind = COIN_NONE;
    endcase
  end

endmodule

// File: rtl/vend_next_state.sv
module vend_next_state
  import vend_pkg::*;
(
  input  vstate_t    cur,
  input  coin_kind_t kind,
  output vstate_t    nxt,
  output logic       fire
);

  logic real_coin;

  assign real_coin = (kind == COIN_DIME) || (kind == COIN_QUARTER);

  always_comb begin
    nxt  = cur;
    fire = 1'b0;
    if (real_coin) begin
      unique case (cur)
        ST_IDLE: begin
          nxt = (kind == COIN_DIME) ? ST_TEN : ST_QTR;
        end
        ST_TEN: begin
          if (kind == COIN_DIME) begin
            nxt = ST_TWENTY;
          end else begin
            nxt  = ST_IDLE;
            fire = 1'b1;
          end
        end
        ST_TWENTY, ST_QTR: begin
          nxt  = ST_IDLE;
          fire = 1'b1;
        end
        default: begin
          nxt = ST_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/vend_state_reg.sv
module vend_state_reg
  import vend_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  vstate_t nxt,
  input  logic    fire,
  output vstate_t cur,
  output logic    pulse
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur   <= ST_IDLE;
      pulse <= 1'b0;
    end else begin
      cur   <= nxt;
      pulse <= fire;
    end
  end

endmodule

// File: rtl/coin_vend_ctrl.sv
module coin_vend_ctrl
  import vend_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] coin_code,
  output logic [STATE_W-1:0] acc_state,
  output logic              vend
);

  coin_kind_t kind;
  vstate_t    cur;
  vstate_t    nxt;
  logic       fire;

  vend_coin_decode u_dec (
    .code (coin_code),
    .kind (kind)
  );

  vend_next_state u_ns (
    .cur  (cur),
    .kind (kind),
    .nxt  (nxt),
    .fire (fire)
  );

  vend_state_reg u_reg (
    .clk   (clk),
    .rst   (rst),
    .nxt   (nxt),
    .fire  (fire),
    .cur   (cur),
    .pulse (vend)
  );

  assign acc_state = cur;

endmodule

// File: rtl/coin_vend_ctrl_chk.sv
module coin_vend_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] coin_code,
  input logic [1:0] acc_state,
  input logic       vend
);

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (acc_state == 2'b00 && !vend));

  // R2
  no_coin_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (coin_code == 2'b00) |=> (acc_state == $past(acc_state) && !vend));

  // R3
  bad_code_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (coin_code == 2'b11) |=> (acc_state == $past(acc_state) && !vend));

  // R4
  idle_dime_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_state == 2'b00 && coin_code == 2'b01) |=> (acc_state == 2'b10 && !vend));

  // R4
  idle_qtr_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_state == 2'b00 && coin_code == 2'b10) |=> (acc_state == 2'b11 && !vend));

  // R5
  ten_dime_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_state == 2'b10 && coin_code == 2'b01) |=> (acc_state == 2'b01 && !vend));

  // R5
  ten_qtr_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_state == 2'b10 && coin_code == 2'b10) |=> (acc_state == 2'b00 && vend));

  // R6
  twenty_coin_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_state == 2'b01 && $countones(coin_code) == 1) |=> (acc_state == 2'b00 && vend));

  // R7
  qtr_coin_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_state == 2'b11 && $countones(coin_code) == 1) |=> (acc_state == 2'b00 && vend));

  // R8
  vend_single_chk: assert property (@(posedge clk) disable iff (rst)
    vend |=> !vend);

  // R8
  vend_at_idle_chk: assert property (@(posedge clk) disable iff (rst)
    vend |-> (acc_state == 2'b00));

endmodule

bind coin_vend_ctrl coin_vend_ctrl_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .coin_code (coin_code),
  .acc_state (acc_state),
  .vend      (vend)
);

// File: tb/coin_vend_ctrl_test.sv
module coin_vend_ctrl_test;

  localparam logic [1:0] NONE = 2'b00;
  localparam logic [1:0] DIME = 2'b01;
  localparam logic [1:0] QTR  = 2'b10;
  localparam logic [1:0] BAD  = 2'b11;

  localparam logic [1:0] S_IDLE = 2'b00;
  localparam logic [1:0] S_TEN  = 2'b10;
  localparam logic [1:0] S_TWN  = 2'b01;
  localparam logic [1:0] S_QTR  = 2'b11;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] coin_code = 2'b00;
  logic [1:0] acc_state;
  logic       vend;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  coin_vend_ctrl uut (
    .clk       (clk),
    .rst       (rst),
    .coin_code (coin_code),
    .acc_state (acc_state),
    .vend      (vend)
  );

  task automatic check(input string req, input logic [1:0] exp_st, input logic exp_v);
    n_run++;
    if (acc_state !== exp_st || vend !== exp_v) begin
      n_fail++;
      $display("FAIL %s: state=%b vend=%b expected state=%b vend=%b",
               req, acc_state, vend, exp_st, exp_v);
    end
  endtask

  // drive at negedge, sample at following negedge
  task automatic put(input logic [1:0] code);
    coin_code = code;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    put(QTR);
    put(DIME);
    rst = 1'b0;
    coin_code = NONE;
  endtask

  task automatic t_reset();
    put(DIME);
    put(QTR);
    do_reset();
    check("R1", S_IDLE, 1'b0);
    put(NONE);
    check("R1", S_IDLE, 1'b0);
  endtask

  task automatic t_hold();
    do_reset();
    put(DIME);
    check("R4", S_TEN, 1'b0);
    put(NONE);
    check("R2", S_TEN, 1'b0);
    put(NONE);
    check("R2", S_TEN, 1'b0);
    put(BAD);
    check("R3", S_TEN, 1'b0);
    put(DIME);
    check("R5", S_TWN, 1'b0);
    put(BAD);
    check("R3", S_TWN, 1'b0);
    put(NONE);
    check("R2", S_TWN, 1'b0);
    do_reset();
    put(BAD);
    check("R3", S_IDLE, 1'b0);
    put(QTR);
    check("R4", S_QTR, 1'b0);
    put(BAD);
    check("R3", S_QTR, 1'b0);
  endtask

  task automatic t_paths();
    do_reset();
    put(DIME); put(QTR);
    check("R5", S_IDLE, 1'b1);
    put(NONE);
    check("R8", S_IDLE, 1'b0);
    put(DIME); put(DIME); put(DIME);
    check("R6", S_IDLE, 1'b1);
    put(NONE);
    check("R8", S_IDLE, 1'b0);
    put(DIME); put(DIME); put(QTR);
    check("R6", S_IDLE, 1'b1);
    put(QTR); put(DIME);
    check("R7", S_IDLE, 1'b1);
    put(QTR); put(QTR);
    check("R7", S_IDLE, 1'b1);
  endtask

  task automatic t_back_to_back();
    do_reset();
    put(QTR);
    check("R4", S_QTR, 1'b0);
    put(QTR);
    check("R7", S_IDLE, 1'b1);
    put(QTR);
    check("R8", S_QTR, 1'b0);
    put(QTR);
    check("R7", S_IDLE, 1'b1);
    put(DIME);
    check("R8", S_TEN, 1'b0);
    put(DIME);
    check("R5", S_TWN, 1'b0);
    put(DIME);
    check("R6", S_IDLE, 1'b1);
    put(DIME);
    check("R8", S_TEN, 1'b0);
    put(NONE);
    check("R8", S_TEN, 1'b0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_hold();
    t_paths();
    t_back_to_back();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule